// File: doc/BRIEF.md
# Two-Bit-Instruction Boundary-Scan Test Port Controller

This block is the test access port for a device that carries a boundary-scan chain. It is clocked by the test clock. It walks the sixteen-state controller graph under the mode-select input and holds a two-bit instruction register. It owns two data registers: a one-bit bypass stage and a 32-bit identification word. The active instruction picks which register sits between the serial input and the serial output.

When the active instruction addresses the boundary chain, the block drives that chain through capture, shift and update strobes and a mode flag. The chain lives outside this block. Its serial output comes back on a dedicated input and is routed to the port's serial output. A synchronous active-high reset takes the place of the optional asynchronous test reset. Holding the mode-select input high for five clocks gives the same result.

Top module: `scan_tap`

## Requirements
- R1: A high `rst` at a rising `tck`, or five consecutive rising `tck` edges with `tms` high from any state, puts the controller in Test-Logic-Reset. Passing through that state makes IDCODE (code 2'b10) the active instruction, so `bsc_extest` is low.
- R2: The controller moves between its sixteen states on the rising edge of `tck` along the standard test-port graph. Capture, shift and update in each of the instruction and data branches are reached by the usual `tms` sequences.
- R3: The instruction register is two bits wide. It is shifted least-significant bit first, and Capture-IR loads 2'b01, so the first two bits seen on `tdo` during Shift-IR are 1 and then 0.
- R4: The active instruction changes only when Update-IR is left. Throughout Shift-IR, Exit1-IR and Update-IR, `bsc_extest` keeps its previous value.
- R5: The instruction codes are 2'b00 external test, 2'b01 sample/preload, 2'b10 IDCODE and 2'b11 bypass. The boundary chain is selected for 2'b00 and 2'b01 only.
- R6: Under IDCODE, Capture-DR loads a 32-bit word laid out as version in [31:28], part number in [27:14], derivative in [13:12], manufacturer in [11:1] and a constant 1 in [0]. Shift-DR sends it out least-significant bit first.
- R7: Under bypass, Capture-DR clears the single bypass bit, and Shift-DR delays `tdi` by exactly one `tck` on its way to `tdo`, so the first bit out is 0.
- R8: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR.
- R9: While the boundary chain is selected, `bsc_capture`, `bsc_shift` and `bsc_update` are high in Capture-DR, Shift-DR and Update-DR respectively. They are all low under the other instructions, and at most one of them is high at a time.
- R10: `bsc_extest` is high exactly while external test is the active instruction. Under sample/preload it is low, which keeps the normal core-to-pin path.
- R11: In Shift-DR with the boundary chain selected, `tdo` carries the value `bsc_so` held at the preceding falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset, acting as the test reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial test data in |
| bsc_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial test data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for `tdo`, high in the shift states |
| bsc_capture | output | 1 | Boundary chain capture strobe |
| bsc_shift | output | 1 | Boundary chain shift strobe |
| bsc_update | output | 1 | Boundary chain update strobe |
| bsc_extest | output | 1 | Boundary chain mode flag: break the core-to-pin path |

## Verification
The bench looks first at the instruction register's timing. A design that applied shifted bits before Update-IR would raise or drop the mode flag in the middle of an instruction scan. The bench also checks the captured 2'b01 pattern, which a register shifting in the wrong direction would send out as 0-then-1. It reads the identification word bit by bit and looks for a one-cycle delay through bypass with a leading 0. A reversed field order, a missing capture or a zero-length bypass would corrupt or shift those streams. Finally, it parks the controller inside Shift-DR under external test and leaves with five high mode-select cycles, and it also pulses reset. A controller that failed to reload IDCODE would keep the mode flag raised and send out boundary data in place of the identification word.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  localparam int IR_W = 2;

  typedef enum logic [IR_W-1:0] {
    OP_EXTEST = 2'b00,
    OP_SAMPLE = 2'b01,
    OP_IDCODE = 2'b10,
    OP_BYPASS = 2'b11
  } tap_op_e;

  // Fixed pattern loaded into the instruction shift stage in Capture-IR
  localparam logic [IR_W-1:0] IR_CAPTURE = 2'b01;

  // Consecutive high TMS cycles that always reach Test-Logic-Reset
  localparam int TMS_RESET_RUN = 5;

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck) begin
    if (rst) state <= ST_RESET;
    else     state <= nxt;
  end

  // Run-length counter of high TMS samples, used only by the check below
  localparam int CNT_W = $clog2(TMS_RESET_RUN + 1);
  logic [CNT_W-1:0] hi_run;

  always_ff @(posedge tck) begin
    if (rst || !tms)                        hi_run <= '0;
    else if (hi_run != CNT_W'(TMS_RESET_RUN)) hi_run <= hi_run + 1'b1;
  end

  p_tms_run_reset_r1: assert property (@(posedge tck) disable iff (rst)
    (hi_run == CNT_W'(TMS_RESET_RUN)) |-> (state == ST_RESET));

  p_shift_dr_entry_r2: assert property (@(posedge tck) disable iff (rst)
    (state == ST_SHF_DR) |-> ($past(state) inside {ST_CAP_DR, ST_SHF_DR, ST_EX2_DR}));

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       rst,
  input  tap_state_e state,
  input  logic       tdi,
  output tap_op_e    op,
  output logic       ir_so
);

  logic [IR_W-1:0] ir_sh;

  always_ff @(posedge tck) begin
    if (rst) begin
      ir_sh <= IR_CAPTURE;
      op    <= OP_IDCODE;
    end else begin
      if (state == ST_CAP_IR)      ir_sh <= IR_CAPTURE;
      else if (state == ST_SHF_IR) ir_sh <= {tdi, ir_sh[IR_W-1:1]};

      if (state == ST_RESET)       op <= OP_IDCODE;
      else if (state == ST_UPD_IR) op <= tap_op_e'(ir_sh);
    end
  end

  assign ir_so = ir_sh[0];

  p_ir_default_r1: assert property (@(posedge tck) disable iff (rst)
    (state == ST_RESET) |=> (op == OP_IDCODE));

  p_ir_hold_r4: assert property (@(posedge tck) disable iff (rst)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(op));

  p_ir_capture_r3: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_IR) |=> (ir_so == 1'b1));

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int VER_W  = 4,
  parameter int PART_W = 14,
  parameter int DRV_W  = 2,
  parameter int MFR_W  = 11,
  parameter logic [VER_W-1:0]  VERSION = 4'h1,
  parameter logic [PART_W-1:0] PART    = 14'h1A5C,
  parameter logic [DRV_W-1:0]  DERIV   = 2'b01,
  parameter logic [MFR_W-1:0]  MFR     = 11'h2B3
) (
  input  logic       tck,
  input  logic       rst,
  input  tap_state_e state,
  input  tap_op_e    op,
  input  logic       tdi,
  output logic       byp_so,
  output logic       id_so
);

  localparam int ID_W = VER_W + PART_W + DRV_W + MFR_W + 1;
  localparam logic [ID_W-1:0] ID_WORD = {VERSION, PART, DERIV, MFR, 1'b1};

  logic            byp_q;
  logic [ID_W-1:0] id_sh;

  always_ff @(posedge tck) begin
    if (rst) begin
      byp_q <= 1'b0;
      id_sh <= ID_WORD;
    end else if (state == ST_CAP_DR) begin
      byp_q <= 1'b0;
      if (op == OP_IDCODE) id_sh <= ID_WORD;
    end else if (state == ST_SHF_DR) begin
      if (op == OP_BYPASS) byp_q <= tdi;
      if (op == OP_IDCODE) id_sh <= {tdi, id_sh[ID_W-1:1]};
    end
  end

  assign byp_so = byp_q;
  assign id_so  = id_sh[0];

  p_id_lsb_one_r6: assert property (@(posedge tck) disable iff (rst)
    (state == ST_CAP_DR && op == OP_IDCODE) |=> (id_so == 1'b1));

  p_byp_delay_r7: assert property (@(posedge tck) disable iff (rst)
    (state == ST_SHF_DR && op == OP_BYPASS) |=> (byp_so == $past(tdi)));

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int VER_W  = 4,
  parameter int PART_W = 14,
  parameter int DRV_W  = 2,
  parameter int MFR_W  = 11,
  parameter logic [VER_W-1:0]  VERSION = 4'h1,
  parameter logic [PART_W-1:0] PART    = 14'h1A5C,
  parameter logic [DRV_W-1:0]  DERIV   = 2'b01,
  parameter logic [MFR_W-1:0]  MFR     = 11'h2B3
) (
  input  logic tck,
  input  logic rst,
  input  logic tms,
  input  logic tdi,
  input  logic bsc_so,
  output logic tdo,
  output logic tdo_oe,
  output logic bsc_capture,
  output logic bsc_shift,
  output logic bsc_update,
  output logic bsc_extest
);

  tap_state_e state;
  tap_op_e    op;
  logic       ir_so, byp_so, id_so;

  scan_tap_fsm u_fsm (
    .tck   (tck),
    .rst   (rst),
    .tms   (tms),
    .state (state)
  );

  scan_tap_ir u_ir (
    .tck   (tck),
    .rst   (rst),
    .state (state),
    .tdi   (tdi),
    .op    (op),
    .ir_so (ir_so)
  );

  scan_tap_dr #(
    .VER_W(VER_W), .PART_W(PART_W), .DRV_W(DRV_W), .MFR_W(MFR_W),
    .VERSION(VERSION), .PART(PART), .DERIV(DERIV), .MFR(MFR)
  ) u_dr (
    .tck    (tck),
    .rst    (rst),
    .state  (state),
    .op     (op),
    .tdi    (tdi),
    .byp_so (byp_so),
    .id_so  (id_so)
  );

  // Boundary chain is addressed by the two external-pin instructions
  logic bsc_sel;
  assign bsc_sel     = (op == OP_EXTEST) || (op == OP_SAMPLE);
  assign bsc_capture = bsc_sel && (state == ST_CAP_DR);
  assign bsc_shift   = bsc_sel && (state == ST_SHF_DR);
  assign bsc_update  = bsc_sel && (state == ST_UPD_DR);
  assign bsc_extest  = (op == OP_EXTEST);

  // Output stage: relaunched on the falling edge, half a cycle after the shift
  logic in_shift_ir, in_shift_dr;
  assign in_shift_ir = (state == ST_SHF_IR);
  assign in_shift_dr = (state == ST_SHF_DR);

  always_ff @(negedge tck) begin
    if (rst) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift_ir || in_shift_dr;
      if (in_shift_ir) begin
        tdo <= ir_so;
      end else if (in_shift_dr) begin
        case (op)
          OP_IDCODE: tdo <= id_so;
          OP_BYPASS: tdo <= byp_so;
          default:   tdo <= bsc_so;
        endcase
      end else begin
        tdo <= 1'b0;
      end
    end
  end

  p_oe_only_shift_r8: assert property (@(posedge tck) disable iff (rst)
    tdo_oe |-> (state == ST_SHF_IR || state == ST_SHF_DR));

  p_strobe_onehot_r9: assert property (@(posedge tck) disable iff (rst)
    $onehot0({bsc_capture, bsc_shift, bsc_update}));

  p_extest_selects_r10: assert property (@(posedge tck) disable iff (rst)
    bsc_extest |-> !(op inside {OP_IDCODE, OP_BYPASS}));

endmodule

// File: tb/scan_tap_bench.sv
`timescale 1ns/1ps
module scan_tap_bench;

  localparam logic [3:0]  B_VER  = 4'h1;
  localparam logic [13:0] B_PART = 14'h1A5C;
  localparam logic [1:0]  B_DRV  = 2'b01;
  localparam logic [10:0] B_MFR  = 11'h2B3;

  logic tck = 1'b0, rst = 1'b1, tms = 1'b1, tdi = 1'b0, bsc_so = 1'b0;
  logic tdo, tdo_oe, bsc_capture, bsc_shift, bsc_update, bsc_extest;

  always #2.5 tck = ~tck;

  scan_tap #(.VERSION(B_VER), .PART(B_PART), .DERIV(B_DRV), .MFR(B_MFR)) u_scan_tap (
    .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .bsc_so(bsc_so),
    .tdo(tdo), .tdo_oe(tdo_oe), .bsc_capture(bsc_capture),
    .bsc_shift(bsc_shift), .bsc_update(bsc_update), .bsc_extest(bsc_extest)
  );

  // Expected identification word built from the field layout (R6)
  logic [31:0] id_exp;
  initial id_exp = (32'(B_VER) << 28) | (32'(B_PART) << 14) |
                   (32'(B_DRV) << 12) | (32'(B_MFR) << 1) | 32'd1;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;
  logic cmp_en = 1'b0;

  typedef struct { logic v; string rq; } sb_item_t;
  sb_item_t sb_q[$];

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Driver: one TCK cycle; outputs seen on return belong to the current state
  task automatic step(input logic m, input logic d, input bit c, input logic e, input string rq);
    @(negedge tck); #1;
    tms = m; tdi = d; cmp_en = c;
    if (c) sb_q.push_back('{e, rq});
  endtask

  // Monitor: pops one expected serial bit per compared cycle
  initial forever begin
    @(negedge tck); #2;
    if (cmp_en) begin
      sb_item_t it;
      if (sb_q.size() == 0) begin
        check(1'b0, "scoreboard", 0, 1);
      end else begin
        it = sb_q.pop_front();
        check(tdo === it.v, it.rq, 32'(tdo), 32'(it.v));
        check(tdo_oe === 1'b1, "R8", 32'(tdo_oe), 1);
      end
    end
  end

  // mode: 0 identification, 1 bypass, 2 boundary chain
  task automatic scan_dr(input int n, input logic [31:0] din, input int mode, input logic [31:0] bpat);
    bit b = (mode == 2);
    step(1, 0, 0, 0, "");                       // Run-Test/Idle -> Select-DR
    check(tdo_oe === 1'b0, "R8", 32'(tdo_oe), 0); // idle: driver off
    step(0, 0, 0, 0, "");                       // Select-DR -> Capture-DR
    step(0, 0, 0, 0, "");                       // in Capture-DR
    check(bsc_capture === b, "R9", 32'(bsc_capture), 32'(b));
    bsc_so = bpat[0];
    for (int i = 0; i < n; i++) begin
      logic e;
      string rq;
      if (mode == 0)      begin e = id_exp[i];                   rq = "R6";  end
      else if (mode == 1) begin e = (i == 0) ? 1'b0 : din[i-1];  rq = "R7";  end
      else                begin e = bpat[i];                     rq = "R11"; end
      step(i == n - 1, din[i], 1, e, rq);
      check(bsc_shift === b, "R9", 32'(bsc_shift), 32'(b));
      if (i + 1 < 32) bsc_so = bpat[i+1];
    end
    step(1, 0, 0, 0, "");                       // Exit1-DR -> Update-DR
    step(0, 0, 0, 0, "");                       // in Update-DR
    check(bsc_update === b, "R9", 32'(bsc_update), 32'(b));
  endtask

  task automatic scan_ir(input logic [1:0] code);
    logic old = bsc_extest;
    step(1, 0, 0, 0, "");
    step(1, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");                       // Capture-IR -> Shift-IR
    step(0, code[0], 1, 1'b1, "R3");            // first captured bit is 1
    check(bsc_extest === old, "R4", 32'(bsc_extest), 32'(old));
    step(1, code[1], 1, 1'b0, "R3");            // second captured bit is 0
    step(1, 0, 0, 0, "");                       // in Exit1-IR
    check(bsc_extest === old, "R4", 32'(bsc_extest), 32'(old));
    step(0, 0, 0, 0, "");                       // in Update-IR
    check(bsc_extest === old, "R4", 32'(bsc_extest), 32'(old));
    step(0, 0, 0, 0, "");                       // back in Run-Test/Idle
    check(bsc_extest === (code == 2'b00), "R10", 32'(bsc_extest), 32'(code == 2'b00));
  endtask

  initial begin
    repeat (3) @(posedge tck);
    @(negedge tck); #1;
    check(tdo_oe === 1'b0, "R8", 32'(tdo_oe), 0);
    check(bsc_extest === 1'b0, "R1", 32'(bsc_extest), 0);
    rst = 1'b0; tms = 1'b0;
    step(0, 0, 0, 0, "");

    scan_dr(32, 32'h0, 0, 32'h0);               // R6: default IDCODE after reset (R1)
    scan_ir(2'b11);                             // R5: bypass code
    scan_dr(16, 32'h0000A5C3, 1, 32'h0);        // R7
    scan_dr(8, 32'h000000FF, 1, 32'h0);         // R7 with a run of ones
    scan_ir(2'b00);                             // R10: external test raises the flag
    scan_dr(8, 32'h0, 2, 32'h000000B2);         // R9, R11
    scan_ir(2'b01);                             // R4: flag falls only after update
    scan_dr(6, 32'h0, 2, 32'h0000002D);         // R5 sample keeps chain selected
    check(bsc_extest === 1'b0, "R10", 32'(bsc_extest), 0);
    scan_ir(2'b10);                             // R5: IDCODE code
    scan_dr(32, 32'h0, 0, 32'h0);

    // R1 / R2: park in Shift-DR under external test, leave with five TMS highs
    scan_ir(2'b00);
    step(1, 0, 0, 0, ""); step(0, 0, 0, 0, ""); step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    for (int k = 0; k < 5; k++) step(1, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    step(0, 0, 0, 0, "");
    check(bsc_extest === 1'b0, "R1", 32'(bsc_extest), 0);
    scan_dr(32, 32'h0, 0, 32'h0);

    // R1: synchronous reset pulse while bypass is active
    scan_ir(2'b11);
    @(negedge tck); #1; rst = 1'b1;
    @(negedge tck); #1; rst = 1'b0; tms = 1'b0;
    step(0, 0, 0, 0, "");
    scan_dr(32, 32'h0, 0, 32'h0);

    step(0, 0, 0, 0, "");
    #10;
    check(sb_q.size() == 0, "scoreboard", 32'(sb_q.size()), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge tck);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule